// File: doc/BRIEF.md
# Selectable-Source Event Counter

This block is an 8-bit up-counter whose count events come from one of two kinds of source. In internal mode a free-running 7-bit prescaler, clocked by the system clock, supplies six power-of-two tick rates, from one event every 4 clocks to one every 128. In external mode an asynchronous input pin is synchronized, and the counter advances on its rising edges, its falling edges, or both.

A 3-bit source code and one fine-select bit choose the source. The selection can change at any time. It acts on the next clock and never restarts the prescaler, so internal ticks keep the phase they have had since reset. The block outputs the count and a one-cycle strobe. The strobe is high in exactly the cycles in which the count shows a freshly incremented value. A synchronous clear zeroes the counter and wins over any pending increment.

Top module: `tmr_clksel_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `count` is 0 and `inc_stb` is 0.
- R2: With `src_sel` 001, 010 or 011, the counter steps once every D clocks. D is 8, 32 or 128 when `fine_sel` is 0, and 4, 16 or 64 when `fine_sel` is 1.
- R3: The prescaler runs freely from reset and is never restarted by a change of `src_sel` or `fine_sel`. With divisor D, `inc_stb` is high only after rising edge k counted from reset release, where k mod D equals 1.
- R4: Source codes 000 and 100 stop counting, whatever the value of `fine_sel`. `count` holds and `inc_stb` stays 0.
- R5: Code 101 counts rising edges of `ext_pin`. A rise driven before clock edge 1 shows up as the new count after edge 3, and not after edge 2.
- R6: Code 110 counts falling edges of `ext_pin` only. A rising edge alone leaves the count unchanged.
- R7: Code 111 counts both edges of `ext_pin`, so each complete pulse adds two.
- R8: In the external modes `fine_sel` has no effect on the count.
- R9: The counter wraps from 0xFF to 0x00 on an increment, and `inc_stb` is asserted for that step.
- R10: `clr` high at a clock edge forces `count` to 0 and `inc_stb` to 0, even when a count event falls on that same edge.
- R11: Whenever `inc_stb` is 1, `count` equals its value of the previous cycle plus one (modulo 256). Without `inc_stb` and without a clear in the previous cycle, `count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Source code: stop, internal rate, or external edge mode |
| fine_sel | input | 1 | Picks the finer of the two internal rates per code |
| ext_pin | input | 1 | Asynchronous external count input |
| clr | input | 1 | Synchronous clear of the counter |
| count | output | 8 | Current counter value |
| inc_stb | output | 1 | High in each cycle the count has just advanced |

## Verification
A prescaler that is restarted or mis-tapped shows at the strobe within one divisor period. The spacing between strobes is wrong, or strobes land off the reset-relative phase grid. A synchronizer chain of the wrong depth moves the external count by one clock, and the latency check catches this on the first edge. A wrong edge decode shows as extra or missing counts within one pulse. A broken clear or wrap shows as a wrong count on the very next clock.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int PRE_W  = 7;
  localparam int CNT_W  = 8;
  localparam int SYNC_N = 2;
  localparam int TAP_W  = $clog2(PRE_W);

  // Prescaler bit whose fall marks one period of the chosen rate.
  // Divisor 2^(b+1) corresponds to bit b: code c with fine f gives b = 2c - f.
  function automatic logic [TAP_W-1:0] tap_index(input logic [2:0] code, input logic fine);
    return {code[1:0], 1'b0} - {{(TAP_W-1){1'b0}}, fine};
  endfunction

  function automatic logic is_internal(input logic [2:0] code);
    return (code[2] == 1'b0) && (code[1:0] != 2'b00);
  endfunction

  function automatic logic is_external(input logic [2:0] code);
    return (code[2] == 1'b1) && (code[1:0] != 2'b00);
  endfunction
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
  import tcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] tap_tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      pre_d1 <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      pre_d1 <= pre_q;
    end
  end

  for (genvar b = 0; b < PRE_W; b++) begin : g_fall
    assign tap_tick[b] = pre_d1[b] & ~pre_q[b];
  end

  // R3: a slower tap can only fire together with every faster one
  for (genvar b = 1; b < PRE_W; b++) begin : g_nest
    p_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tap_tick[b] |-> tap_tick[b-1]);
  end
endmodule

// File: rtl/tcs_edge_sync.sv
module tcs_edge_sync
  import tcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise_ev,
  output logic fall_ev
);
  logic [SYNC_N:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[SYNC_N-1:0], pin_async};
  end

  assign rise_ev =  stage_q[SYNC_N-1] & ~stage_q[SYNC_N];
  assign fall_ev = ~stage_q[SYNC_N-1] &  stage_q[SYNC_N];

  // R5: one edge of the pin yields a single-cycle event
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !rise_ev);
  p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !fall_ev);
endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
(
  input  logic [2:0]       src_sel,
  input  logic             fine_sel,
  input  logic [PRE_W-1:0] tap_tick,
  input  logic             rise_ev,
  input  logic             fall_ev,
  output logic             count_ev
);
  always_comb begin
    count_ev = 1'b0;
    if (is_internal(src_sel)) begin
      count_ev = tap_tick[tap_index(src_sel, fine_sel)];
    end else if (is_external(src_sel)) begin
      case (src_sel[1:0])
        2'b01:   count_ev = rise_ev;
        2'b10:   count_ev = fall_ev;
        default: count_ev = rise_ev | fall_ev;
      endcase
    end
  end
endmodule

// File: rtl/tmr_clksel_counter.sv
module tmr_clksel_counter
  import tcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic             fine_sel,
  input  logic             ext_pin,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             inc_stb
);
  logic [PRE_W-1:0] tap_tick;
  logic             rise_ev;
  logic             fall_ev;
  logic             count_ev;

  tcs_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_tick (tap_tick)
  );

  tcs_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev)
  );

  tcs_src_mux u_mux (
    .src_sel  (src_sel),
    .fine_sel (fine_sel),
    .tap_tick (tap_tick),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .count_ev (count_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      inc_stb <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      inc_stb <= 1'b0;
    end else if (count_ev) begin
      count   <= count + 1'b1;
      inc_stb <= 1'b1;
    end else begin
      inc_stb <= 1'b0;
    end
  end

  // R11: the strobe marks exactly the cycles with a fresh increment
  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_stb |-> count == CNT_W'($past(count) + 1'b1));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_stb && !$past(clr)) |-> count == $past(count));
  // R10: clear wins over any event
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !inc_stb));
  // R4: stop codes never produce a strobe
  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[1:0] == 2'b00) |=> !inc_stb);
endmodule

// File: tb/tb_tmr_clksel_counter.sv
module tb_tmr_clksel_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_sel = 3'b000;
  logic       fine_sel = 1'b0;
  logic       ext_pin = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] count;
  logic       inc_stb;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tmr_clksel_counter dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fine_sel(fine_sel),
    .ext_pin(ext_pin), .clr(clr), .count(count), .inc_stb(inc_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for the next strobe, returns the reset-relative edge number
  task automatic wait_stb(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (inc_stb) begin at = cyc; break; end
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    chk(count == 0 && inc_stb == 0, "R1 during reset", count, 0);
    rst_n = 1'b1;
    step(1);
    chk(count == 0 && inc_stb == 0, "R1 after release", count, 0);
  endtask

  task automatic t_divisors();
    for (int c = 1; c <= 3; c++) begin
      for (int f = 0; f <= 1; f++) begin
        int a, b, div, c0;
        div = 1 << (2 * c + 1 - f);
        src_sel = c[2:0]; fine_sel = f[0];
        wait_stb(a);
        wait_stb(a);
        c0 = count;
        wait_stb(b);
        chk(b - a == div, "R2 spacing", b - a, div);
        chk(count == ((c0 + 1) & 255), "R2 step", count, (c0 + 1) & 255);
      end
    end
  endtask

  task automatic t_phase();
    int at;
    src_sel = 3'b011; fine_sel = 1'b0;
    step(37);
    src_sel = 3'b010; fine_sel = 1'b1;  // /16
    for (int i = 0; i < 3; i++) begin
      wait_stb(at);
      chk(at % 16 == 1, "R3 phase /16", at % 16, 1);
    end
    src_sel = 3'b001; fine_sel = 1'b1;  // /4
    for (int i = 0; i < 3; i++) begin
      wait_stb(at);
      chk(at % 4 == 1, "R3 phase /4", at % 4, 1);
    end
  endtask

  task automatic t_stop();
    for (int m = 0; m < 4; m++) begin
      int c0, seen;
      src_sel = (m < 2) ? 3'b000 : 3'b100;
      fine_sel = m[0];
      ext_pin = 1'b0;
      step(1);
      c0 = count; seen = 0;
      for (int i = 0; i < 140; i++) begin
        @(negedge clk);
        ext_pin = i[2];
        if (inc_stb) seen++;
      end
      ext_pin = 1'b0;
      chk(count == c0, "R4 count held", count, c0);
      chk(seen == 0, "R4 no strobe", seen, 0);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      step(3);
      @(negedge clk); ext_pin = 1'b0;
      step(3);
    end
    step(4);
  endtask

  task automatic t_ext_rise();
    int c0;
    src_sel = 3'b101; fine_sel = 1'b0; ext_pin = 1'b0;
    step(5);
    c0 = count;
    ext_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(count == c0, "R5 not after edge 2", count, c0);
    @(posedge clk); @(negedge clk);
    chk(count == c0 + 1 && inc_stb, "R5 after edge 3", count, c0 + 1);
    step(4); ext_pin = 1'b0; step(6);
    chk(count == c0 + 1, "R5 fall ignored", count, c0 + 1);
    c0 = count;
    pulses(5);
    chk(count == c0 + 5, "R5 five pulses", count, c0 + 5);
  endtask

  task automatic t_ext_fall();
    int c0;
    src_sel = 3'b110; fine_sel = 1'b0; ext_pin = 1'b0;
    step(5);
    c0 = count;
    ext_pin = 1'b1; step(6);
    chk(count == c0, "R6 rise ignored", count, c0);
    ext_pin = 1'b0; step(6);
    chk(count == c0 + 1, "R6 fall counted", count, c0 + 1);
    c0 = count;
    pulses(4);
    chk(count == c0 + 4, "R6 four pulses", count, c0 + 4);
  endtask

  task automatic t_ext_both();
    int c0;
    src_sel = 3'b111; fine_sel = 1'b0; ext_pin = 1'b0;
    step(5);
    c0 = count;
    pulses(5);
    chk(count == c0 + 10, "R7 both edges", count, c0 + 10);
  endtask

  task automatic t_fine_ext();
    int c0;
    fine_sel = 1'b1; ext_pin = 1'b0;
    src_sel = 3'b101; step(5);
    c0 = count; pulses(3);
    chk(count == c0 + 3, "R8 rise fine=1", count, c0 + 3);
    src_sel = 3'b111; step(2);
    c0 = count; pulses(3);
    chk(count == c0 + 6, "R8 both fine=1", count, c0 + 6);
  endtask

  task automatic t_wrap();
    int guard = 0;
    do_clear();
    src_sel = 3'b001; fine_sel = 1'b1;
    while (count != 8'hFF && guard < 2000) begin @(negedge clk); guard++; end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (inc_stb) break;
    end
    chk(count == 0 && inc_stb, "R9 wrap to zero", count, 0);
  endtask

  task automatic t_clear();
    int seen = 0;
    src_sel = 3'b001; fine_sel = 1'b1;
    step(3);
    @(negedge clk); clr = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (inc_stb || count != 0) seen++;
    end
    clr = 1'b0;
    chk(seen == 0, "R10 clear wins", seen, 0);
    step(8);
    chk(count == 2, "R10 resumes after clear", count, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_divisors();
    t_phase();
    t_stop();
    t_ext_rise();
    t_ext_fall();
    t_ext_both();
    t_fine_ext();
    t_wrap();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule